// File: doc/BRIEF.md
# Serial Host Interrupt Aggregator

This block sits beside the transfer engine of a serial host controller and combines its error and event conditions into two level interrupt outputs. One output is for errors and one is for events. Error conditions arrive as single-cycle pulses and are captured in a sticky error-flag register. Event conditions are live status levels from the engine: ready for a command, transmit queue empty, and receive queue full. Each source passes through a per-source mask. The masked sources of each line feed a sticky pending bit, and that bit holds the line until software clears it.

Software works through a small register port. Writes take effect on the clock edge. Reads are combinational from the address. There are six registers:

| Address | Register | Access | Bits |
|---|---|---|---|
| 0 | pending | write-1-to-clear | bit 0 error, bit 1 event |
| 1 | line enable | read/write | bit 0 error, bit 1 event |
| 2 | force | write-only | bit 0 error, bit 1 event |
| 3 | error mask | read/write | one bit per error flag |
| 4 | error flags | write-1-to-clear | bit 0 command-while-busy, bit 1 overflow, bit 2 underflow, bit 3 invalid command, bit 4 invalid chip-select index, bit 5 illegal access |
| 5 | event mask | read/write | bit 0 receive full, bit 1 transmit empty, bit 4 ready |

The force register lets software raise either line for test.

Top module: `sirq_hub`

## Requirements
- R1: After reset, registers read as follows: pending 0, enable 0, force 0, error flags 0, event mask 0, error mask 0x1F. Both interrupt outputs are low.
- R2: Bit 0 is the error line and bit 1 is the event line, in each of the pending, enable and force registers.
- R3: A pulse on an error input sets the matching error-flag bit, which then stays set. Writing 1 to a flag bit clears it. If a pulse and a clearing write hit the same bit in the same cycle, the bit is set.
- R4: The error line is driven by three flags: command-while-busy (bit 0), invalid command (bit 3) and invalid chip-select index (bit 4). Each counts only while its error-mask bit is set. Overflow, underflow and illegal access never drive the line.
- R5: The event line is driven by three status levels: receive full (mask bit 0), transmit empty (mask bit 1) and ready (mask bit 4). Each counts only while its event-mask bit is set. Event-mask bits 2, 3 and 5 have no effect.
- R6: A line's pending bit is set on the edge after an active source is seen, and only while that line's enable bit is set. The interrupt output is a registered copy of (pending AND enable), one cycle behind.
- R7: Writing 1 to a pending bit clears it, and the clear wins over a source active in the same cycle. If the source is still active, the bit is set again on the following edge.
- R8: Writing 1 to a force bit sets that line's pending bit on the same edge if the line is enabled. The write does nothing if the line is disabled. The force register always reads as 0.
- R9: Clearing a line's enable bit drops its output one cycle later and leaves its pending bit unchanged. Setting the enable bit again brings the output back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data for reg_addr |
| err_cmd_busy | input | 1 | Pulse: command issued while busy |
| err_overflow | input | 1 | Pulse: transmit queue overflow |
| err_underflow | input | 1 | Pulse: receive queue underflow |
| err_cmd_inval | input | 1 | Pulse: invalid command |
| err_csid_inval | input | 1 | Pulse: invalid chip-select index |
| err_access_inval | input | 1 | Pulse: illegal access |
| st_ready | input | 1 | Level: engine ready for a command |
| st_tx_empty | input | 1 | Level: transmit queue empty |
| st_rx_full | input | 1 | Level: receive queue full |
| irq_err | output | 1 | Error interrupt, level |
| irq_evt | output | 1 | Event interrupt, level |

## Verification
Two pairs of functions can land on the same edge, and they resolve in opposite directions.

The first pair is a write-1 clear of the event pending bit and a receive-full level that is still asserted. To provoke it, the bench holds the source high across the clearing write. It then expects the pending bit to read 0 right after the write edge and 1 one edge later. It also expects the event output to drop for exactly one cycle.

The second pair is an overflow pulse and a write-1 clear of the overflow flag, issued in the same cycle. Here the flag must read back as set.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int ADDR_W    = 3;
  localparam int NUM_LINES = 2;
  localparam int NUM_ERR   = 6;
  localparam int NUM_EVT   = 6;
  localparam int REG_W     = (NUM_ERR > NUM_EVT) ? NUM_ERR : NUM_EVT;

  localparam logic [ADDR_W-1:0] A_PEND    = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FORCE   = 3'd2;
  localparam logic [ADDR_W-1:0] A_ERRMASK = 3'd3;
  localparam logic [ADDR_W-1:0] A_ERRFLAG = 3'd4;
  localparam logic [ADDR_W-1:0] A_EVTMASK = 3'd5;

  localparam int LINE_ERR = 0;
  localparam int LINE_EVT = 1;

  localparam int E_CMDBUSY = 0;
  localparam int E_OVF     = 1;
  localparam int E_UNF     = 2;
  localparam int E_CMDINV  = 3;
  localparam int E_CSIDINV = 4;
  localparam int E_ACCINV  = 5;

  localparam int V_RXFULL  = 0;
  localparam int V_TXEMPTY = 1;
  localparam int V_READY   = 4;

  // flag bits that may drive each line
  localparam logic [NUM_ERR-1:0] ERR_LINE_SRC =
    NUM_ERR'((1 << E_CMDBUSY) | (1 << E_CMDINV) | (1 << E_CSIDINV));
  localparam logic [NUM_EVT-1:0] EVT_LINE_SRC =
    NUM_EVT'((1 << V_RXFULL) | (1 << V_TXEMPTY) | (1 << V_READY));
  localparam logic [NUM_ERR-1:0] ERRMASK_RST = NUM_ERR'(6'h1F);
endpackage

// File: rtl/sirq_sticky.sv
module sirq_sticky #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, q_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // a new event is never lost to a concurrent clear
    always_comb q_d[b] = set_i[b] | (q_q[b] & ~clr_i[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sirq_line.sv
module sirq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic trig_i,
  input  logic clr_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_d, pend_q, irq_d, irq_q;

  always_comb begin
    pend_d = pend_q;
    if (clr_i)              pend_d = 1'b0;
    else if (en_i && trig_i) pend_d = 1'b1;
    irq_d = pend_q & en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/sirq_hub.sv
module sirq_hub
  import sirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              err_cmd_busy,
  input  logic              err_overflow,
  input  logic              err_underflow,
  input  logic              err_cmd_inval,
  input  logic              err_csid_inval,
  input  logic              err_access_inval,
  input  logic              st_ready,
  input  logic              st_tx_empty,
  input  logic              st_rx_full,
  output logic              irq_err,
  output logic              irq_evt
);
  logic [NUM_LINES-1:0] en_q, en_d, pend_q, irq_q, trig, force_w, pend_clr;
  logic [NUM_ERR-1:0]   errmask_q, errmask_d, flags_q, err_pulse, flag_clr;
  logic [NUM_EVT-1:0]   evtmask_q, evtmask_d, evt_lvl;
  logic                 wr_en, wr_errmask, wr_evtmask;

  // write decode
  always_comb begin
    wr_en      = reg_we && (reg_addr == A_ENABLE);
    wr_errmask = reg_we && (reg_addr == A_ERRMASK);
    wr_evtmask = reg_we && (reg_addr == A_EVTMASK);
    pend_clr   = (reg_we && (reg_addr == A_PEND))    ? reg_wdata[NUM_LINES-1:0] : '0;
    force_w    = (reg_we && (reg_addr == A_FORCE))   ? reg_wdata[NUM_LINES-1:0] : '0;
    flag_clr   = (reg_we && (reg_addr == A_ERRFLAG)) ? reg_wdata[NUM_ERR-1:0]   : '0;
  end

  // next state for plain read/write registers, with explicit enables
  always_comb begin
    en_d      = wr_en      ? reg_wdata[NUM_LINES-1:0] : en_q;
    errmask_d = wr_errmask ? reg_wdata[NUM_ERR-1:0]   : errmask_q;
    evtmask_d = wr_evtmask ? reg_wdata[NUM_EVT-1:0]   : evtmask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      errmask_q <= ERRMASK_RST;
      evtmask_q <= '0;
    end else begin
      en_q      <= en_d;
      errmask_q <= errmask_d;
      evtmask_q <= evtmask_d;
    end
  end

  // source vectors in register bit order
  always_comb begin
    err_pulse            = '0;
    err_pulse[E_CMDBUSY] = err_cmd_busy;
    err_pulse[E_OVF]     = err_overflow;
    err_pulse[E_UNF]     = err_underflow;
    err_pulse[E_CMDINV]  = err_cmd_inval;
    err_pulse[E_CSIDINV] = err_csid_inval;
    err_pulse[E_ACCINV]  = err_access_inval;
    evt_lvl              = '0;
    evt_lvl[V_RXFULL]    = st_rx_full;
    evt_lvl[V_TXEMPTY]   = st_tx_empty;
    evt_lvl[V_READY]     = st_ready;
  end

  sirq_sticky #(.W(NUM_ERR)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (err_pulse),
    .clr_i (flag_clr),
    .q_o   (flags_q)
  );

  always_comb begin
    trig[LINE_ERR] = force_w[LINE_ERR] | (|(flags_q & errmask_q & ERR_LINE_SRC));
    trig[LINE_EVT] = force_w[LINE_EVT] | (|(evt_lvl & evtmask_q & EVT_LINE_SRC));
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    sirq_line u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_q[l]),
      .trig_i (trig[l]),
      .clr_i  (pend_clr[l]),
      .pend_o (pend_q[l]),
      .irq_o  (irq_q[l])
    );
  end

  assign irq_err = irq_q[LINE_ERR];
  assign irq_evt = irq_q[LINE_EVT];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PEND:    reg_rdata[NUM_LINES-1:0] = pend_q;
      A_ENABLE:  reg_rdata[NUM_LINES-1:0] = en_q;
      A_ERRMASK: reg_rdata[NUM_ERR-1:0]   = errmask_q;
      A_ERRFLAG: reg_rdata[NUM_ERR-1:0]   = flags_q;
      A_EVTMASK: reg_rdata[NUM_EVT-1:0]   = evtmask_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sirq_hub_chk.sv
module sirq_hub_chk
  import sirq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [REG_W-1:0]     reg_wdata,
  input logic [REG_W-1:0]     reg_rdata,
  input logic                 err_cmd_busy,
  input logic                 irq_err,
  input logic                 irq_evt,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_ERR-1:0]   flags_q
);
  p_err_set_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[LINE_ERR]) |-> $past(en_q[LINE_ERR]));

  p_evt_set_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[LINE_EVT]) |-> $past(en_q[LINE_EVT]));

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_PEND && reg_wdata[LINE_EVT]) |=> !pend_q[LINE_EVT]);

  p_flag_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_cmd_busy |=> flags_q[E_CMDBUSY]);

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[LINE_ERR] |=> !irq_err);

  p_evt_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[LINE_EVT] |=> !irq_evt);

  p_force_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_FORCE) |-> (reg_rdata == '0));
endmodule

bind sirq_hub sirq_hub_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .err_cmd_busy (err_cmd_busy),
  .irq_err      (irq_err),
  .irq_evt      (irq_evt),
  .en_q         (en_q),
  .pend_q       (pend_q),
  .flags_q      (flags_q)
);

// File: tb/sirq_hub_tb.sv
module sirq_hub_tb_top;
  import sirq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic [5:0] errp = '0;  // bit order = error-flag bit order
  logic st_ready = 1'b0, st_tx_empty = 1'b0, st_rx_full = 1'b0;
  logic irq_err, irq_evt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sirq_hub dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_cmd_busy(errp[0]), .err_overflow(errp[1]), .err_underflow(errp[2]),
    .err_cmd_inval(errp[3]), .err_csid_inval(errp[4]), .err_access_inval(errp[5]),
    .st_ready(st_ready), .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full),
    .irq_err(irq_err), .irq_evt(irq_evt)
  );

  // {event mask[5:0], ready, tx_empty, rx_full, expected event irq}
  localparam logic [9:0] EVT_TAB [8] = '{
    {6'h01, 3'b001, 1'b1},
    {6'h02, 3'b010, 1'b1},
    {6'h10, 3'b100, 1'b1},
    {6'h01, 3'b010, 1'b0},
    {6'h2C, 3'b111, 1'b0},
    {6'h00, 3'b111, 1'b0},
    {6'h13, 3'b100, 1'b1},
    {6'h10, 3'b011, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] v);
    reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); errp[idx] = 1'b1;
    @(negedge clk); errp[idx] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [REG_W-1:0] v;
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    rd(A_PEND, v);    check("R1 pending", 8'(v), 8'h00);
    rd(A_ENABLE, v);  check("R1 enable", 8'(v), 8'h00);
    rd(A_FORCE, v);   check("R1 force", 8'(v), 8'h00);
    rd(A_ERRMASK, v); check("R1 errmask", 8'(v), 8'h1F);
    rd(A_ERRFLAG, v); check("R1 errflags", 8'(v), 8'h00);
    rd(A_EVTMASK, v); check("R1 evtmask", 8'(v), 8'h00);
    check("R1 irqs", {6'b0, irq_err, irq_evt}, 8'h00);

    // R5 / R2 event table
    wr(A_ENABLE, 6'h02);
    for (int i = 0; i < 8; i++) begin
      wr(A_EVTMASK, EVT_TAB[i][9:4]);
      {st_ready, st_tx_empty, st_rx_full} = EVT_TAB[i][3:1];
      idle(3);
      check($sformatf("R5 evt irq entry %0d", i), {7'b0, irq_evt}, {7'b0, EVT_TAB[i][0]});
      rd(A_PEND, v);
      check($sformatf("R2 evt pending bit1 entry %0d", i), 8'(v), {6'b0, EVT_TAB[i][0], 1'b0});
      {st_ready, st_tx_empty, st_rx_full} = 3'b000;
      wr(A_PEND, 6'h02);
      idle(2);
    end

    // R7 clear beats a live source, then re-sets
    wr(A_EVTMASK, 6'h01); st_rx_full = 1'b1; idle(3);
    rd(A_PEND, v); check("R7 pending before clear", 8'(v), 8'h02);
    @(negedge clk); reg_we = 1'b1; reg_addr = A_PEND; reg_wdata = 6'h02;
    @(negedge clk); reg_we = 1'b0;
    rd(A_PEND, v); check("R7 cleared on write edge", 8'(v), 8'h00);
    @(negedge clk);
    rd(A_PEND, v); check("R7 re-set next edge", 8'(v), 8'h02);
    check("R7 irq dips one cycle", {7'b0, irq_evt}, 8'h00);
    @(negedge clk);
    check("R7 irq back", {7'b0, irq_evt}, 8'h01);
    st_rx_full = 1'b0; wr(A_PEND, 6'h02); wr(A_ENABLE, 6'h00); idle(2);

    // R3 sticky flag, set wins over simultaneous clear
    @(negedge clk); reg_we = 1'b1; reg_addr = A_ERRFLAG; reg_wdata = 6'h02; errp[1] = 1'b1;
    @(negedge clk); reg_we = 1'b0; errp[1] = 1'b0;
    rd(A_ERRFLAG, v); check("R3 set wins", 8'(v), 8'h02);
    idle(2);
    rd(A_ERRFLAG, v); check("R3 sticky", 8'(v), 8'h02);
    wr(A_ERRFLAG, 6'h02);
    rd(A_ERRFLAG, v); check("R3 w1c", 8'(v), 8'h00);

    // R4 error sources
    wr(A_ENABLE, 6'h01);
    pulse(1); pulse(2); pulse(5); idle(3);
    check("R4 non-line flags no irq", {7'b0, irq_err}, 8'h00);
    rd(A_ERRFLAG, v); check("R4 flags 1,2,5", 8'(v), 8'h26);
    wr(A_ERRFLAG, 6'h3F);
    pulse(3); idle(2);
    check("R4 cmd_inval irq", {7'b0, irq_err}, 8'h01);
    wr(A_ERRFLAG, 6'h3F); wr(A_PEND, 6'h01); idle(2);
    check("R7 error cleared", {7'b0, irq_err}, 8'h00);
    wr(A_ERRMASK, 6'h17);
    pulse(3); idle(3);
    check("R4 masked cmd_inval", {7'b0, irq_err}, 8'h00);
    rd(A_PEND, v); check("R4 masked no pending", 8'(v), 8'h00);
    pulse(4); idle(2);
    check("R4 csid_inval irq", {7'b0, irq_err}, 8'h01);
    wr(A_ERRFLAG, 6'h3F); wr(A_PEND, 6'h01); wr(A_ERRMASK, 6'h1F);
    pulse(0); idle(2);
    check("R4 cmd_busy irq", {7'b0, irq_err}, 8'h01);
    wr(A_ERRFLAG, 6'h3F); wr(A_PEND, 6'h01); idle(2);

    // R8 force
    @(negedge clk); reg_we = 1'b1; reg_addr = A_FORCE; reg_wdata = 6'h01;
    @(negedge clk); reg_we = 1'b0;
    rd(A_PEND, v); check("R8 force sets pending same edge", 8'(v), 8'h01);
    @(negedge clk);
    check("R8 force irq", {7'b0, irq_err}, 8'h01);
    rd(A_FORCE, v); check("R8 force reads zero", 8'(v), 8'h00);
    wr(A_FORCE, 6'h02);
    rd(A_PEND, v); check("R8 disabled line ignores force", 8'(v), 8'h01);
    idle(1);
    check("R8 evt stays low", {7'b0, irq_evt}, 8'h00);

    // R9 enable gating
    wr(A_ENABLE, 6'h00); idle(1);
    check("R9 irq drops", {7'b0, irq_err}, 8'h00);
    rd(A_PEND, v); check("R9 pending kept", 8'(v), 8'h01);
    wr(A_ENABLE, 6'h01); idle(1);
    check("R9 irq restored", {7'b0, irq_err}, 8'h01);
    wr(A_PEND, 6'h01); idle(2);
    check("R9 final clear", {7'b0, irq_err}, 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule